// File: doc/BRIEF.md
# Exposed-Latency Retire Collector

This block sits between a set of statically scheduled functional-unit pipelines and the belt. Every pipeline may start at most one operation per clock. Each operation carries a latency code, and its result appears a fixed number of cycles later. No hazard check, rename or reordering takes place. A pipeline has a separate output register for every latency it supports, so two results from one pipeline can finish in the same cycle. In every cycle the collector gathers all finishing results into one packed drop bundle, together with a count.

Calls are atomic for operations in flight. A call captures every operation issued up to and including the call cycle. If such a result falls due while the callee runs, it is parked in a small holding buffer instead of dropping. The cycle after the return, the parked results lead the bundle in the order they fell due. The arithmetic is a stub: a unit of latency L returns its operand plus L. The belt storage itself lies outside this block.

The drop side is a stream with a valid flag and no ready. The pipelines are exposed and cannot stall, so the consumer must accept every bundle in the cycle it is presented. Issue inputs are plain per-cycle strobes with no handshake.

Top module: `belt_retire_collector`

## Requirements
- R1: While reset is asserted and right after it, drop_cnt is 0, drop_vld is 0, every drop slot is 0 and hold_err is 0.
- R2: An operation issued on pipe p in cycle t with latency code c (0..NLAT-1, latency c+1) and operand x yields x+c+1 (modulo 2^DW) in the drop bundle during cycle t+c+1. This applies when the operation is not held by a call.
- R3: A pipeline that issues in consecutive cycles with different latency codes can finish two results in the same cycle, and both of them drop.
- R4: The bundle of a cycle holds exactly drop_cnt results. Live results occupy consecutive slots, ordered by pipeline index ascending and then by latency ascending. Slots at index drop_cnt and above read 0.
- R5: call_i taken in cycle c opens a call. A result of an operation issued in cycle c or earlier that falls due in a cycle after c, up to and including the return cycle, does not drop in that cycle.
- R6: In the cycle after ret_i is taken, the held results fill slots 0 onward. They are ordered by due cycle, then pipe, then latency. That cycle's live results follow them.
- R7: call_i while a call is open has no effect, and ret_i while no call is open has no effect. When both pins are high during an open call, the return is taken.
- R8: Operations issued while a call is open drop at their normal due cycle.
- R9: If more than HOLD results would be held, the first HOLD are kept and the rest are discarded. hold_err rises in the cycle after the overflowing cycle and stays high until reset.
- R10: drop_vld is 1 exactly when drop_cnt is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | NPIPE | Per-pipe issue strobe |
| iss_lat | input | NPIPE*LW | Per-pipe latency code (latency = code+1) |
| iss_opnd | input | NPIPE*DW | Per-pipe operand |
| call_i | input | 1 | Call issues this cycle |
| ret_i | input | 1 | Return issues this cycle |
| drop_vld | output | 1 | Bundle carries at least one result |
| drop_cnt | output | $clog2(OUT+1) | Number of results in the bundle |
| drop_data | output | OUT*DW | Packed bundle, OUT = HOLD+NPIPE*NLAT slots |
| hold_err | output | 1 | Sticky holding-buffer overflow flag |

## Verification
A result issued in cycle t with latency code c is due in the bundle exactly c+1 cycles later. The bench therefore files each issue in a table under its due cycle and compares the whole bundle on the falling edge of that cycle. A held result is expected one cycle after the taken return, and an overflow is expected on hold_err one cycle after the cycle that overflowed. The bench model decides from issue and call cycles alone whether a result is held. Sweeps cover every latency pair across the two pipes and within one pipe, then long pseudo-random traffic with calls and stray call/return pins.

// File: rtl/belt_retire_pkg.sv
package belt_retire_pkg;
  localparam int unsigned DEF_NPIPE = 4;
  localparam int unsigned DEF_NLAT  = 4;
  localparam int unsigned DEF_HOLD  = 8;
  localparam int unsigned DEF_DW    = 32;

  function automatic int unsigned code_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/belt_fu_stub.sv
module belt_fu_stub #(
  parameter int unsigned NLAT = 4,
  parameter int unsigned DW   = 32,
  parameter int unsigned LW   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iss_vld,
  input  logic [LW-1:0]            iss_lat,
  input  logic [DW-1:0]            iss_opnd,
  input  logic                     call_take,
  input  logic                     ret_take,
  output logic [NLAT-1:0]          res_vld,
  output logic [NLAT-1:0]          res_dfr,
  output logic [NLAT-1:0][DW-1:0]  res_data
);
  for (genvar g = 0; g < NLAT; g++) begin : g_lat
    localparam int unsigned L = g + 1;
    logic [L-1:0]         v;
    logic [L-1:0]         f;
    logic [L-1:0][DW-1:0] d;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v <= '0;
        f <= '0;
        d <= '0;
      end else begin
        v[0] <= iss_vld && (iss_lat == LW'(g));
        d[0] <= iss_opnd + DW'(L);
        f[0] <= call_take;
        for (int s = 1; s < int'(L); s++) begin
          v[s] <= v[s-1];
          d[s] <= d[s-1];
          f[s] <= (f[s-1] & ~ret_take) | call_take;
        end
      end
    end

    assign res_vld[g]  = v[L-1];
    assign res_dfr[g]  = f[L-1];
    assign res_data[g] = d[L-1];
  end
endmodule

// File: rtl/belt_hold_buf.sv
module belt_hold_buf #(
  parameter int unsigned NSRC = 16,
  parameter int unsigned HOLD = 8,
  parameter int unsigned DW   = 32,
  localparam int unsigned HCW = $clog2(HOLD + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          src_vld,
  input  logic [NSRC-1:0]          src_dfr,
  input  logic [NSRC-1:0][DW-1:0]  src_data,
  input  logic                     release_now,
  output logic [HCW-1:0]           hold_cnt,
  output logic [HOLD-1:0][DW-1:0]  hold_data,
  output logic                     hold_err
);
  logic [HCW-1:0]          n_cnt;
  logic [HOLD-1:0][DW-1:0] n_data;
  logic                    ovf;

  always_comb begin
    n_cnt  = hold_cnt;
    n_data = hold_data;
    ovf    = 1'b0;
    if (release_now) begin
      n_cnt = '0;
    end else begin
      for (int k = 0; k < int'(NSRC); k++) begin
        if (src_vld[k] && src_dfr[k]) begin
          if (n_cnt < HCW'(HOLD)) begin
            n_data[n_cnt] = src_data[k];
            n_cnt         = n_cnt + 1'b1;
          end else begin
            ovf = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt  <= '0;
      hold_data <= '0;
      hold_err  <= 1'b0;
    end else begin
      hold_cnt  <= n_cnt;
      hold_data <= n_data;
      hold_err  <= hold_err | ovf;
    end
  end
endmodule

// File: rtl/belt_drop_merge.sv
module belt_drop_merge #(
  parameter int unsigned NSRC = 16,
  parameter int unsigned HOLD = 8,
  parameter int unsigned DW   = 32,
  localparam int unsigned HCW = $clog2(HOLD + 1),
  localparam int unsigned OUT = HOLD + NSRC,
  localparam int unsigned PW  = $clog2(OUT + 1)
) (
  input  logic [NSRC-1:0]          src_vld,
  input  logic [NSRC-1:0]          src_dfr,
  input  logic [NSRC-1:0][DW-1:0]  src_data,
  input  logic                     release_now,
  input  logic [HCW-1:0]           hold_cnt,
  input  logic [HOLD-1:0][DW-1:0]  hold_data,
  output logic [PW-1:0]            drop_cnt,
  output logic [OUT-1:0][DW-1:0]   drop_data
);
  logic [PW-1:0] pos;

  always_comb begin
    pos       = '0;
    drop_data = '0;
    if (release_now) begin
      for (int h = 0; h < int'(HOLD); h++) begin
        if (HCW'(h) < hold_cnt) drop_data[h] = hold_data[h];
      end
      pos = PW'(hold_cnt);
    end
    for (int k = 0; k < int'(NSRC); k++) begin
      if (src_vld[k] && !src_dfr[k]) begin
        drop_data[pos] = src_data[k];
        pos            = pos + 1'b1;
      end
    end
    drop_cnt = pos;
  end
endmodule

// File: rtl/belt_retire_collector.sv
module belt_retire_collector
  import belt_retire_pkg::*;
#(
  parameter int unsigned NPIPE = DEF_NPIPE,
  parameter int unsigned NLAT  = DEF_NLAT,
  parameter int unsigned HOLD  = DEF_HOLD,
  parameter int unsigned DW    = DEF_DW,
  localparam int unsigned LW   = code_w(NLAT),
  localparam int unsigned NSRC = NPIPE * NLAT,
  localparam int unsigned OUT  = HOLD + NSRC,
  localparam int unsigned PW   = $clog2(OUT + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPIPE-1:0]           iss_vld,
  input  logic [NPIPE-1:0][LW-1:0]   iss_lat,
  input  logic [NPIPE-1:0][DW-1:0]   iss_opnd,
  input  logic                       call_i,
  input  logic                       ret_i,
  output logic                       drop_vld,
  output logic [PW-1:0]              drop_cnt,
  output logic [OUT-1:0][DW-1:0]     drop_data,
  output logic                       hold_err
);
  localparam int unsigned HCW = $clog2(HOLD + 1);

  logic                    in_call;
  logic                    release_q;
  logic                    call_take;
  logic                    ret_take;
  logic [NSRC-1:0]         src_vld;
  logic [NSRC-1:0]         src_dfr;
  logic [NSRC-1:0][DW-1:0] src_data;
  logic [HCW-1:0]          hold_cnt;
  logic [HOLD-1:0][DW-1:0] hold_data;

  // A return wins over a call while a call is open; a stray pin is dropped.
  assign call_take = call_i & ~in_call;
  assign ret_take  = ret_i & in_call;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_call   <= 1'b0;
      release_q <= 1'b0;
    end else begin
      in_call   <= call_take | (in_call & ~ret_take);
      release_q <= ret_take;
    end
  end

  // Source index p*NLAT+l gives pipe-major, latency-minor bundle order.
  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    belt_fu_stub #(.NLAT(NLAT), .DW(DW), .LW(LW)) u_fu (
      .clk      (clk),
      .rst_n    (rst_n),
      .iss_vld  (iss_vld[p]),
      .iss_lat  (iss_lat[p]),
      .iss_opnd (iss_opnd[p]),
      .call_take(call_take),
      .ret_take (ret_take),
      .res_vld  (src_vld[p*NLAT +: NLAT]),
      .res_dfr  (src_dfr[p*NLAT +: NLAT]),
      .res_data (src_data[p*NLAT +: NLAT])
    );
  end

  belt_hold_buf #(.NSRC(NSRC), .HOLD(HOLD), .DW(DW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_vld    (src_vld),
    .src_dfr    (src_dfr),
    .src_data   (src_data),
    .release_now(release_q),
    .hold_cnt   (hold_cnt),
    .hold_data  (hold_data),
    .hold_err   (hold_err)
  );

  belt_drop_merge #(.NSRC(NSRC), .HOLD(HOLD), .DW(DW)) u_merge (
    .src_vld    (src_vld),
    .src_dfr    (src_dfr),
    .src_data   (src_data),
    .release_now(release_q),
    .hold_cnt   (hold_cnt),
    .hold_data  (hold_data),
    .drop_cnt   (drop_cnt),
    .drop_data  (drop_data)
  );

  assign drop_vld = |drop_cnt;
endmodule

// File: rtl/belt_retire_chk.sv
module belt_retire_chk #(
  parameter int unsigned NPIPE = 4,
  parameter int unsigned LW    = 2,
  parameter int unsigned HCW   = 4,
  parameter int unsigned PW    = 5,
  parameter int unsigned OUT   = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPIPE-1:0]         iss_vld,
  input logic [NPIPE-1:0][LW-1:0] iss_lat,
  input logic                     call_i,
  input logic                     ret_i,
  input logic                     in_call,
  input logic                     release_q,
  input logic [HCW-1:0]           hold_cnt,
  input logic [PW-1:0]            drop_cnt,
  input logic                     drop_vld,
  input logic                     hold_err
);
  AST_LAT1_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld[0] && iss_lat[0] == '0 && !in_call && !call_i) |=> (drop_cnt != '0)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt <= PW'(OUT)); // R4
  AST_HOLD_ONLY_IN_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cnt > $past(hold_cnt)) |-> $past(in_call)); // R5
  AST_RELEASE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    release_q |=> (hold_cnt == '0)); // R6
  AST_CALL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_call && call_i && !ret_i) |=> in_call); // R7
  AST_RET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_call && ret_i && !call_i) |=> !in_call); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hold_err |=> hold_err); // R9
  AST_ERR_FROM_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_err) |-> $past(in_call)); // R9
  AST_VLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    drop_vld == (drop_cnt != '0)); // R10
endmodule

bind belt_retire_collector belt_retire_chk #(
  .NPIPE(NPIPE), .LW(LW), .HCW(HCW), .PW(PW), .OUT(OUT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .iss_vld  (iss_vld),
  .iss_lat  (iss_lat),
  .call_i   (call_i),
  .ret_i    (ret_i),
  .in_call  (in_call),
  .release_q(release_q),
  .hold_cnt (hold_cnt),
  .drop_cnt (drop_cnt),
  .drop_vld (drop_vld),
  .hold_err (hold_err)
);

// File: tb/sim_belt_retire_collector.sv
`timescale 1ns/1ps
module sim_belt_retire_collector;
  localparam int NP  = 2;
  localparam int NL  = 4;
  localparam int HD  = 4;
  localparam int DW  = 8;
  localparam int OUT = HD + NP * NL;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                    rst_n;
  logic [NP-1:0]           iss_vld;
  logic [NP-1:0][1:0]      iss_lat;
  logic [NP-1:0][DW-1:0]   iss_opnd;
  logic                    call_i, ret_i;
  logic                    drop_vld;
  logic [3:0]              drop_cnt;
  logic [OUT-1:0][DW-1:0]  drop_data;
  logic                    hold_err;

  belt_retire_collector #(.NPIPE(NP), .NLAT(NL), .HOLD(HD), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_lat(iss_lat),
    .iss_opnd(iss_opnd), .call_i(call_i), .ret_i(ret_i), .drop_vld(drop_vld),
    .drop_cnt(drop_cnt), .drop_data(drop_data), .hold_err(hold_err)
  );

  int checks = 0;
  int errors = 0;

  // Bench model: results filed under their due cycle.
  bit           sv [16][NP][NL];
  logic [7:0]   sd [16][NP][NL];
  int           si [16][NP][NL];
  logic [7:0]   q [HD];
  int           qn;
  bit           m_in_call, m_rel, m_err;
  int           m_call_cyc;
  int           k;
  string        ptag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, k, act, exp);
    end
  endtask

  function automatic int pend();
    int n = 0;
    for (int s = 0; s < 16; s++)
      for (int p = 0; p < NP; p++)
        for (int l = 0; l < NL; l++)
          if (sv[s][p][l] && s != (k % 16)) n++;
    return n;
  endfunction

  task automatic model_clear();
    for (int s = 0; s < 16; s++)
      for (int p = 0; p < NP; p++)
        for (int l = 0; l < NL; l++) sv[s][p][l] = 1'b0;
    qn = 0; m_in_call = 0; m_rel = 0; m_err = 0; m_call_cyc = -1; k = 0;
  endtask

  task automatic step(input logic [1:0] v, input logic [1:0][1:0] lt,
                      input logic [1:0][7:0] op, input logic c, input logic r);
    logic [7:0] e [OUT];
    int en;
    bit ovf;
    string t;
    @(negedge clk);
    en = 0; ovf = 0; t = ptag;
    for (int i = 0; i < OUT; i++) e[i] = 8'h00;
    if (m_rel) begin
      for (int i = 0; i < qn; i++) begin e[en] = q[i]; en++; end
      qn = 0; m_rel = 0; t = "R6";
    end else if (m_in_call) begin
      t = "R5";
    end
    chk(hold_err == m_err, "R9", "hold_err", int'(hold_err), int'(m_err));
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < NL; l++)
        if (sv[k % 16][p][l]) begin
          if (m_in_call && si[k % 16][p][l] <= m_call_cyc) begin
            if (qn < HD) begin q[qn] = sd[k % 16][p][l]; qn++; end
            else ovf = 1;
          end else begin
            e[en] = sd[k % 16][p][l]; en++;
          end
          sv[k % 16][p][l] = 1'b0;
        end
    chk(int'(drop_cnt) == en, "R4", "drop_cnt", int'(drop_cnt), en);
    chk(drop_vld == (en != 0), "R10", "drop_vld", int'(drop_vld), int'(en != 0));
    for (int i = 0; i < OUT; i++)
      chk(drop_data[i] == e[i], t, $sformatf("slot %0d", i), int'(drop_data[i]), int'(e[i]));
    m_err = m_err | ovf;
    iss_vld = v; iss_lat = lt; iss_opnd = op; call_i = c; ret_i = r;
    for (int p = 0; p < NP; p++)
      if (v[p]) begin
        int due = k + int'(lt[p]) + 1;
        sv[due % 16][p][lt[p]] = 1'b1;
        sd[due % 16][p][lt[p]] = op[p] + 8'(lt[p]) + 8'd1;
        si[due % 16][p][lt[p]] = k;
      end
    if (m_in_call) begin
      if (r) begin m_in_call = 0; m_rel = 1; end
    end else if (c) begin
      m_in_call = 1; m_call_cyc = k;
    end
    k++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(2'b00, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; iss_vld = '0; iss_lat = '0; iss_opnd = '0; call_i = 0; ret_i = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(drop_cnt == 0 && drop_vld == 0 && drop_data == '0, "R1", "reset bundle",
          int'(drop_cnt), 0);
      chk(hold_err == 0, "R1", "reset hold_err", int'(hold_err), 0);
    end
    rst_n = 1'b1;
    model_clear();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected finished", k);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0][1:0] lt;
    logic [1:0][7:0] op;
    logic [1:0]      v;
    do_reset();

    // R2: every latency pair across both pipes, same issue cycle.
    ptag = "R2";
    for (int a = 0; a < NL; a++)
      for (int b = 0; b < NL; b++) begin
        lt[0] = 2'(a); lt[1] = 2'(b);
        op[0] = 8'(16 * a + b); op[1] = 8'(200 + a - b);
        step(2'b11, lt, op, 1'b0, 1'b0);
        idle(4);
      end

    // R3: one pipe, back-to-back issues of every latency pair.
    ptag = "R3";
    for (int a = 0; a < NL; a++)
      for (int b = 0; b < NL; b++) begin
        lt = '0; lt[1] = 2'(a); op = '0; op[1] = 8'(a * 7 + 3);
        step(2'b10, lt, op, 1'b0, 1'b0);
        lt[1] = 2'(b); op[1] = 8'(b * 11 + 50);
        step(2'b10, lt, op, 1'b0, 1'b0);
        idle(4);
      end

    // R7: stray call inside an open call and stray return outside one.
    ptag = "R7";
    lt[0] = 2'd3; lt[1] = 2'd3; op[0] = 8'd10; op[1] = 8'd20;
    step(2'b11, lt, op, 1'b0, 1'b0);
    step(2'b00, lt, op, 1'b1, 1'b0);
    step(2'b00, lt, op, 1'b1, 1'b0);
    lt[0] = 2'd0; op[0] = 8'd33;
    step(2'b01, lt, op, 1'b1, 1'b0);
    idle(1);
    step(2'b00, lt, op, 1'b0, 1'b1);
    idle(1);
    step(2'b00, lt, op, 1'b0, 1'b1);
    idle(5);

    // R8: pseudo-random traffic with calls, callee issues and stray pins.
    ptag = "R8";
    for (int i = 0; i < 600; i++) begin
      v = 2'($urandom % 4);
      lt[0] = 2'($urandom % 4); lt[1] = 2'($urandom % 4);
      op[0] = 8'($urandom); op[1] = 8'($urandom);
      if (!m_in_call && ($urandom % 8 == 0) && pend() <= HD)
        step(2'b00, lt, op, 1'b1, 1'b0);
      else if (m_in_call)
        step(v, lt, op, 1'($urandom % 6 == 0), 1'($urandom % 3 == 0));
      else
        step(v, lt, op, 1'b0, 1'($urandom % 12 == 0));
    end
    while (m_in_call) step(2'b00, lt, op, 1'b0, 1'b1);
    idle(6);

    // R9: eight deferred results against a four-entry buffer.
    ptag = "R9";
    lt[0] = 2'd3; lt[1] = 2'd3;
    for (int i = 0; i < 4; i++) begin
      op[0] = 8'(i); op[1] = 8'(100 + i);
      step(2'b11, lt, op, (i == 3) ? 1'b1 : 1'b0, 1'b0);
    end
    idle(4);
    step(2'b00, lt, op, 1'b0, 1'b1);
    idle(6);
    chk(hold_err == 1'b1, "R9", "sticky flag", int'(hold_err), 1);

    do_reset();
    @(negedge clk);
    chk(hold_err == 1'b0, "R1", "flag after reset", int'(hold_err), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule